// File: doc/BRIEF.md
# Half-Step Capable Output Clock Divider

This block turns a fast tick clock into a slower output clock and sends that clock to several output channels. Each channel has a true pin and a complement pin. The tick clock runs at four times the nominal oscillator rate. Because of this, every supported ratio, including the half-integer ratio 1.5, becomes an even number of ticks per output period. The output is high for exactly half of each period.

A 3-bit ratio code selects the divide ratio. The code present on the pins while master reset is asserted becomes the starting ratio. After reset, a new code is accepted only on a one-tick update strobe. The accepted code does not take effect until the next rising edge of the output. The period in progress therefore always completes at the old ratio, and no shortened pulse can appear.

Master reset is synchronous. While it is high, the counters are cleared and every true output is held low and every complement output is held high. Both of these output levels are forced at once, without waiting for a tick edge.

Top module: `clk_div_frac`

## Requirements
- R1: The ratio code maps to a half period of H ticks as follows: 000→2 (ratio 1), 001→3 (ratio 1.5), 010→4 (ratio 2), 011→6 (ratio 3), 100→8 (ratio 4), 101→12 (ratio 6), 110→16 (ratio 8), 111→24 (ratio 12). The output period is 2H ticks.
- R2: Every high phase and every low phase of the output lasts exactly H ticks of the active ratio, which gives a 50% duty cycle.
- R3: While `rst` is high, every `out_p` bit is 0 and every `out_n` bit is 1, with no delay. A tick edge with `rst` high clears the counter and loads the ratio code from `n_code`.
- R4: After `rst` is released, the output stays low for exactly H ticks and then rises. This low time is half a period at the code loaded during reset.
- R5: All channels carry the same level at all times.
- R6: Outside reset, `out_n` is the bitwise inverse of `out_p`.
- R7: When `upd` is high on a tick edge, the code on `n_code` at that edge is captured. It takes effect at the first rising output edge that follows, and the phases already under way complete at the old H. This holds whether the strobe arrives in a high phase or in a low phase.
- R8: If several strobes arrive before that rising edge, only the code from the last strobe takes effect.
- R9: A change on `n_code` without a strobe has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, four times the oscillator rate |
| rst | input | 1 | Synchronous master reset, active high |
| n_code | input | 3 | Ratio code |
| upd | input | 1 | Update strobe that captures `n_code` |
| out_p | output | NCH | True output clock, one bit per channel |
| out_n | output | NCH | Complement output clock, one bit per channel |

## Verification
A wrong counter value or a wrong active code shows at the ports as a high or low phase of the wrong length. This is visible within one half period, at most 24 ticks. A wrong pending-code state is different: it only appears as a wrong phase length starting at the next rising edge. So a code applied early or late is caught at the first phase boundary after the strobe. The two channels and the complement pins are compared on every tick, so a gating error is seen within one tick.

// File: rtl/clk_div_frac.sv
module clk_div_frac #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     n_code,
  input  logic           upd,
  output logic [NCH-1:0] out_p,
  output logic [NCH-1:0] out_n
);
  localparam int MAX_HALF = 24;
  localparam int CNT_W = $clog2(MAX_HALF + 1);

  function automatic logic [CNT_W-1:0] half_of(input logic [2:0] c);
    case (c)
      3'd0: half_of = CNT_W'(2);
      3'd1: half_of = CNT_W'(3);
      3'd2: half_of = CNT_W'(4);
      3'd3: half_of = CNT_W'(6);
      3'd4: half_of = CNT_W'(8);
      3'd5: half_of = CNT_W'(12);
      3'd6: half_of = CNT_W'(16);
      default: half_of = CNT_W'(24);
    endcase
  endfunction

  logic [2:0]       cur_code, pend_code;
  logic             pend_v;
  logic [CNT_W-1:0] cnt;
  logic             lvl;

  wire [CNT_W-1:0] half   = half_of(cur_code);
  wire             at_end = (cnt == half - CNT_W'(1));
  wire             ck     = lvl & ~rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      lvl       <= 1'b0;
      cur_code  <= n_code;
      pend_code <= n_code;
      pend_v    <= 1'b0;
    end else begin
      if (at_end) begin
        cnt <= '0;
        lvl <= ~lvl;
        if (!lvl && pend_v) begin
          cur_code <= pend_code;
          pend_v   <= 1'b0;
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
      if (upd) begin
        pend_code <= n_code;
        pend_v    <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign out_p[i] = ck;
    assign out_n[i] = ~ck;
  end

  assert_reset_levels_R3: assert property (@(posedge clk)
    rst |-> (out_p == '0 && out_n == '1));

  assert_complement_R6: assert property (@(posedge clk) disable iff (rst)
    out_n == ~out_p);

  assert_channels_match_R5: assert property (@(posedge clk) disable iff (rst)
    out_p == {NCH{out_p[0]}});

  assert_code_swap_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (cur_code != $past(cur_code)) |-> ($rose(lvl) || $past(rst)));

  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt < half);
endmodule

// File: tb/tb_clk_div_frac.sv
module tb_clk_div_frac;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd = 1'b0;
  logic [2:0] n_code = 3'd2;
  logic [NCH-1:0] out_p, out_n;

  always #10 clk = ~clk;

  clk_div_frac #(.NCH(NCH)) dut (
    .clk(clk), .rst(rst), .n_code(n_code), .upd(upd),
    .out_p(out_p), .out_n(out_n)
  );

  typedef struct {
    bit    lvl;
    int    len;
    string req;
  } seg_t;

  seg_t exp_q[$];
  int checks = 0;
  int errors = 0;

  function automatic int half_t(input logic [2:0] c);
    case (c)
      3'd0: return 2;
      3'd1: return 3;
      3'd2: return 4;
      3'd3: return 6;
      3'd4: return 8;
      3'd5: return 12;
      3'd6: return 16;
      default: return 24;
    endcase
  endfunction

  function automatic void push(input bit l, input int n, input string r);
    seg_t s;
    s.lvl = l;
    s.len = n;
    s.req = r;
    exp_q.push_back(s);
  endfunction

  // R1 R2: each period is a high phase then a low phase of H ticks
  function automatic void push_periods(input logic [2:0] c, input int k, input string r);
    for (int i = 0; i < k; i++) begin
      push(1'b1, half_t(c), r);
      push(1'b0, half_t(c), r);
    end
  endfunction

  // Monitor: measures phase lengths in ticks and compares them with the queue
  bit seg_lvl;
  int seg_len;
  bit tracking = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      tracking = 1'b0;
    end else begin
      checks++;
      if (out_n !== ~out_p) begin
        errors++;
        $display("FAIL R6 out_n=%b expected %b", out_n, ~out_p);
      end
      checks++;
      if (out_p !== {NCH{out_p[0]}}) begin
        errors++;
        $display("FAIL R5 out_p=%b expected all equal", out_p);
      end
      if (!tracking) begin
        tracking = 1'b1;
        seg_lvl = out_p[0];
        seg_len = 1;
      end else if (out_p[0] == seg_lvl) begin
        seg_len++;
      end else begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected phase lvl=%0d len=%0d expected none", seg_lvl, seg_len);
        end else begin
          seg_t s;
          s = exp_q.pop_front();
          if (s.lvl != seg_lvl || s.len != seg_len) begin
            errors++;
            $display("FAIL %s phase lvl=%0d len=%0d expected lvl=%0d len=%0d",
                     s.req, seg_lvl, seg_len, s.lvl, s.len);
          end
        end
        seg_lvl = out_p[0];
        seg_len = 1;
      end
    end
  end

  task automatic wait_empty();
    while (exp_q.size() != 0) begin
      @(negedge clk);
      #1;
    end
  endtask

  // R3 R4: reset forces levels, loads the code, first rise after H ticks
  task automatic do_reset(input logic [2:0] c);
    rst = 1'b1;
    n_code = c;
    exp_q.delete();
    #1;
    checks++;
    if (out_p !== '0 || out_n !== '1) begin
      errors++;
      $display("FAIL R3 out_p=%b out_n=%b expected %b %b", out_p, out_n, {NCH{1'b0}}, {NCH{1'b1}});
    end
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_p !== '0 || out_n !== '1) begin
      errors++;
      $display("FAIL R3 held out_p=%b out_n=%b expected %b %b", out_p, out_n, {NCH{1'b0}}, {NCH{1'b1}});
    end
    rst = 1'b0;
    push(1'b0, half_t(c), "R4");
  endtask

  task automatic strobe(input logic [2:0] c);
    n_code = c;
    upd = 1'b1;
    @(posedge clk);
    #1;
    upd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired with %0d phases pending expected 0", exp_q.size());
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] old;
    do_reset(3'd0);
    push_periods(3'd0, 3, "R1");
    old = 3'd0;
    // R7: strobe during a high phase, walking through every code
    for (int c = 1; c < 8; c++) begin
      wait_empty();
      strobe(3'(c));
      push(1'b1, half_t(old), "R7");
      push(1'b0, half_t(old), "R7");
      push_periods(3'(c), 2, "R1");
      old = 3'(c);
    end
    // R8: two strobes within one low phase, the last one wins
    wait_empty();
    push(1'b1, half_t(old), "R2");
    wait_empty();
    strobe(3'd3);
    @(posedge clk);
    #1;
    strobe(3'd1);
    push(1'b0, half_t(old), "R8");
    push_periods(3'd1, 3, "R8");
    old = 3'd1;
    // R9: code change without a strobe is ignored
    wait_empty();
    n_code = 3'd6;
    push(1'b1, half_t(old), "R9");
    push(1'b0, half_t(old), "R9");
    push_periods(old, 2, "R9");
    // R7: strobe during a low phase
    wait_empty();
    push(1'b1, half_t(old), "R2");
    wait_empty();
    strobe(3'd4);
    push(1'b0, half_t(old), "R7");
    push_periods(3'd4, 2, "R7");
    // R3: reset in a high phase, then restart at a new code
    wait_empty();
    do_reset(3'd5);
    push_periods(3'd5, 2, "R1");
    wait_empty();
    do_reset(3'd1);
    push_periods(3'd1, 3, "R2");
    wait_empty();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule